// File: doc/BRIEF.md
# Floating-Point Register NaN-Boxing Unit

This combinational unit sits between a 64-bit floating-point register file and datapaths that work on 16-bit or 32-bit values. In box direction, it takes a narrow result held in the low bits of a 64-bit word and forces every bit above the narrow width to one before the word is written to a register. In unbox direction, it takes a register value that is about to feed a narrow operation. It checks that the value carries the all-ones upper pattern. If the pattern is present, the value passes through. If it is not, the value is replaced by the canonical quiet NaN of that width, and the NaN is itself boxed.

The same boxing applies whether or not a double-precision datapath exists in the system. In double-precision mode both directions pass the 64-bit word through unchanged. The unit has no clock, no reset and no state, so its output follows its inputs within the same cycle.

Top module: `fpbox_unit`

## Requirements
- R1: Box direction (unbox_mode=0) with prec_sel=1 (single) gives fp_out = {32'hFFFFFFFF, fp_in[31:0]}.
- R2: Box direction with prec_sel=0 (half) gives fp_out = {48'hFFFFFFFFFFFF, fp_in[15:0]}.
- R3: Unbox direction (unbox_mode=1) with prec_sel=1 passes fp_in unchanged when fp_in[63:32] is all ones, including the threshold value 64'hFFFFFFFF00000000.
- R4: Unbox direction with prec_sel=1 gives 64'hFFFFFFFF7FC00000 when any bit of fp_in[63:32] is zero, including 64'hFFFFFFFEFFFFFFFF, just below the threshold.
- R5: Unbox direction with prec_sel=0 passes fp_in unchanged when fp_in[63:16] is all ones, including the threshold value 64'hFFFFFFFFFFFF0000.
- R6: Unbox direction with prec_sel=0 gives 64'hFFFFFFFFFFFF7E00 when any bit of fp_in[63:16] is zero, including 64'hFFFFFFFFFFFEFFFF.
- R7: prec_sel=2 (double) passes fp_in to fp_out unchanged in both directions.
- R8: The unused code prec_sel=3 behaves exactly like prec_sel=2.
- R9: For prec_sel 0 and 1, fp_out always has every bit above the narrow width set, in both directions.
- R10: The unit holds no state. fp_out reflects a new input within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fp_in | input | 64 | Register value or narrow result in the low bits |
| prec_sel | input | 2 | 0 half, 1 single, 2 double, 3 treated as double |
| unbox_mode | input | 1 | 0 box for write, 1 check for read |
| fp_out | output | 64 | Boxed or checked 64-bit value |

## Verification
Every result is due in the same cycle as its stimulus, because no register lies between any input and fp_out. The bench changes the inputs at the falling clock edge and samples fp_out one nanosecond later, well before the next rising edge. One check changes the inputs a second time inside the same cycle, which shows that no clock edge is needed for the output to update. The threshold values, and the values just below them, are applied directly. Random words are then run, about half of them with the upper pattern forced valid.

// File: rtl/fpbox_pkg.sv
package fpbox_pkg;

    localparam int FLEN      = 64;
    localparam int NUM_LANES = 2;

    typedef enum logic [1:0] {
        PREC_HALF   = 2'd0,
        PREC_SINGLE = 2'd1,
        PREC_DOUBLE = 2'd2,
        PREC_ALT    = 2'd3
    } prec_e;

    // lane 0 carries half precision, lane 1 single precision
    function automatic int lane_width(input int idx);
        return (idx == 0) ? 16 : 32;
    endfunction

    function automatic int lane_exp(input int idx);
        return (idx == 0) ? 5 : 8;
    endfunction

endpackage

// File: rtl/fpbox_lane.sv
module fpbox_lane #(
    parameter int FLEN = 64,
    parameter int NW   = 32,
    parameter int EW   = 8
) (
    input  logic [FLEN-1:0] value_i,
    output logic [FLEN-1:0] boxed_o,
    output logic [FLEN-1:0] nan_o,
    output logic            valid_o
);
    localparam int UW = FLEN - NW;
    localparam int MW = NW - EW - 2;
    localparam logic [FLEN-1:0] UPPER_MASK = {{UW{1'b1}}, {NW{1'b0}}};
    localparam logic [NW-1:0]   QNAN_NARROW = {1'b0, {EW{1'b1}}, 1'b1, {MW{1'b0}}};

    always_comb begin
        valid_o = (value_i >= UPPER_MASK);
        boxed_o = UPPER_MASK | {{UW{1'b0}}, value_i[NW-1:0]};
        nan_o   = UPPER_MASK | {{UW{1'b0}}, QNAN_NARROW};
    end

    always_comb begin
        if (!$isunknown(value_i)) begin
            AST_LANE_VALID_UPPER: assert (valid_o == (&value_i[FLEN-1:NW])); // R3
        end
    end

endmodule

// File: rtl/fpbox_select.sv
module fpbox_select
    import fpbox_pkg::*;
(
    input  logic [FLEN-1:0]                 full_i,
    input  logic [NUM_LANES-1:0][FLEN-1:0]  boxed_i,
    input  logic [NUM_LANES-1:0][FLEN-1:0]  nan_i,
    input  logic [NUM_LANES-1:0]            valid_i,
    input  logic [1:0]                      prec_i,
    input  logic                            unbox_i,
    output logic [FLEN-1:0]                 value_o
);
    typedef struct packed {
        logic [FLEN-1:0] value;
    } sel_t;

    sel_t sel_d;
    int   lane;

    always_comb begin
        lane = (prec_i == PREC_HALF) ? 0 : 1;
        if (prec_i == PREC_HALF || prec_i == PREC_SINGLE) begin
            if (!unbox_i) begin
                sel_d.value = boxed_i[lane];
            end else if (valid_i[lane]) begin
                sel_d.value = full_i;
            end else begin
                sel_d.value = nan_i[lane];
            end
        end else begin
            sel_d.value = full_i;
        end
        value_o = sel_d.value;
    end

endmodule

// File: rtl/fpbox_unit.sv
module fpbox_unit
    import fpbox_pkg::*;
(
    input  logic [63:0] fp_in,
    input  logic [1:0]  prec_sel,
    input  logic        unbox_mode,
    output logic [63:0] fp_out
);
    logic [NUM_LANES-1:0][FLEN-1:0] boxed_w;
    logic [NUM_LANES-1:0][FLEN-1:0] nan_w;
    logic [NUM_LANES-1:0]           valid_w;

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        fpbox_lane #(
            .FLEN (FLEN),
            .NW   (lane_width(g)),
            .EW   (lane_exp(g))
        ) u_lane (
            .value_i (fp_in),
            .boxed_o (boxed_w[g]),
            .nan_o   (nan_w[g]),
            .valid_o (valid_w[g])
        );
    end

    fpbox_select u_sel (
        .full_i  (fp_in),
        .boxed_i (boxed_w),
        .nan_i   (nan_w),
        .valid_i (valid_w),
        .prec_i  (prec_sel),
        .unbox_i (unbox_mode),
        .value_o (fp_out)
    );

    always_comb begin
        if (!$isunknown({fp_in, prec_sel, unbox_mode})) begin
            if (prec_sel == 2'd0) begin
                AST_HALF_UPPER_ONES: assert (&fp_out[63:16]); // R9
            end
            if (prec_sel == 2'd1) begin
                AST_SINGLE_UPPER_ONES: assert (&fp_out[63:32]); // R9
            end
            if (prec_sel == 2'd1 && !unbox_mode) begin
                AST_SINGLE_LOW_KEPT: assert (fp_out[31:0] == fp_in[31:0]); // R1
            end
            if (prec_sel == 2'd0 && !unbox_mode) begin
                AST_HALF_LOW_KEPT: assert (fp_out[15:0] == fp_in[15:0]); // R2
            end
            if (prec_sel == 2'd1 && unbox_mode && !(&fp_in[63:32])) begin
                AST_SINGLE_BAD_NAN: assert (fp_out == 64'hFFFF_FFFF_7FC0_0000); // R4
            end
            if (prec_sel == 2'd0 && unbox_mode && !(&fp_in[63:16])) begin
                AST_HALF_BAD_NAN: assert (fp_out == 64'hFFFF_FFFF_FFFF_7E00); // R6
            end
            if (prec_sel[1]) begin
                AST_WIDE_PASS: assert (fp_out == fp_in); // R7
            end
        end
    end

endmodule

// File: tb/fpbox_unit_bench.sv
module fpbox_unit_bench;
    logic        clk = 1'b0;
    logic [63:0] fp_in = '0;
    logic [1:0]  prec_sel = '0;
    logic        unbox_mode = 1'b0;
    logic [63:0] fp_out;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    fpbox_unit u_fpbox_unit (
        .fp_in      (fp_in),
        .prec_sel   (prec_sel),
        .unbox_mode (unbox_mode),
        .fp_out     (fp_out)
    );

    function automatic logic [63:0] model(input logic [63:0] v, input logic [1:0] p, input logic u);
        if (p == 2'd1) begin
            if (!u) return {32'hFFFFFFFF, v[31:0]};
            return (v[63:32] == 32'hFFFFFFFF) ? v : 64'hFFFFFFFF7FC00000;
        end
        if (p == 2'd0) begin
            if (!u) return {48'hFFFFFFFFFFFF, v[15:0]};
            return (v[63:16] == 48'hFFFFFFFFFFFF) ? v : 64'hFFFFFFFFFFFF7E00;
        end
        return v;
    endfunction

    function automatic string tag_of(input logic [63:0] v, input logic [1:0] p, input logic u);
        if (p == 2'd3) return "R8";
        if (p == 2'd2) return "R7";
        if (p == 2'd1) return !u ? "R1" : ((v[63:32] == '1) ? "R3" : "R4");
        return !u ? "R2" : ((v[63:16] == '1) ? "R5" : "R6");
    endfunction

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic apply(input logic [63:0] v, input logic [1:0] p, input logic u);
        @(negedge clk);
        fp_in = v; prec_sel = p; unbox_mode = u;
        #1;
        check(tag_of(v, p, u), fp_out, model(v, p, u));
        if (!p[1]) begin
            check("R9", {48'h0, (p == 2'd0) ? fp_out[15:0] : 16'h0} |
                  (p == 2'd0 ? {fp_out[63:16], 16'h0} : {fp_out[63:32], 32'h0}),
                  {(p == 2'd0) ? 48'hFFFFFFFFFFFF : {32'hFFFFFFFF, fp_out[31:16]}, fp_out[15:0]} &
                  (p == 2'd0 ? 64'hFFFFFFFFFFFFFFFF : 64'hFFFFFFFF00000000));
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] r;
        void'($urandom(32'd4711));
        #1;
        // initial inputs all zero: half box of zero, R2
        check("R2", fp_out, 64'hFFFFFFFFFFFF0000);

        apply(64'h0123456789ABCDEF, 2'd1, 1'b0);  // R1
        apply(64'h0123456789ABCDEF, 2'd0, 1'b0);  // R2
        apply(64'hFFFFFFFF00000000, 2'd1, 1'b1);  // R3 threshold
        apply(64'hFFFFFFFF3F800000, 2'd1, 1'b1);  // R3
        apply(64'hFFFFFFFEFFFFFFFF, 2'd1, 1'b1);  // R4 just below
        apply(64'h7FFFFFFFFFFFFFFF, 2'd1, 1'b1);  // R4
        apply(64'hFFFFFFFFFFFF0000, 2'd0, 1'b1);  // R5 threshold
        apply(64'hFFFFFFFFFFFF3C00, 2'd0, 1'b1);  // R5
        apply(64'hFFFFFFFFFFFEFFFF, 2'd0, 1'b1);  // R6 just below
        apply(64'hFFFFFFFF3F800000, 2'd0, 1'b1);  // R6 single-boxed read as half
        apply(64'h0000000000000000, 2'd0, 1'b1);  // R6
        apply(64'h0123456789ABCDEF, 2'd2, 1'b0);  // R7
        apply(64'h0123456789ABCDEF, 2'd2, 1'b1);  // R7
        apply(64'h00000000DEADBEEF, 2'd3, 1'b0);  // R8
        apply(64'h00000000DEADBEEF, 2'd3, 1'b1);  // R8

        // R10: second change within one cycle, no clock edge between
        @(negedge clk);
        fp_in = 64'h1; prec_sel = 2'd1; unbox_mode = 1'b1;
        #0.5;
        fp_in = 64'hFFFFFFFF12345678;
        #0.5;
        check("R10", fp_out, 64'hFFFFFFFF12345678);

        for (int i = 0; i < 3000; i++) begin
            r = {$urandom, $urandom};
            case ($urandom % 3)
                0: r[63:32] = '1;
                1: r[63:16] = '1;
                default: ;
            endcase
            apply(r, 2'($urandom % 4), 1'($urandom % 2));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule